// File: doc/BRIEF.md
# Core Store Buffer with Load Forwarding

This block sits between one core's store port and that core's private cache. A store is taken in as soon as a slot is free and is acknowledged to the core in the same handshake, so the core never waits for coherence traffic. Each held entry waits until the coherence engine reports two events for its line: the line fill has returned, and all invalidation acknowledgements have been collected. A store to a line the core already holds writable is marked complete when it enters. Complete entries drain into the cache over a valid/ready write port, one per cycle, oldest complete entry first.

Loads search the buffer before the cache. When one or more held entries match the load address, the youngest of them supplies the data and byte mask. A miss tells the core to read the cache. A barrier pulse marks every entry held at that moment. While any marked entry remains, no unmarked entry may drain. Stores that come after the barrier still enter the buffer, so the core keeps running. Without a barrier, a younger store to an owned line may reach the cache ahead of an older store that is still waiting on coherence.

Stream rules: a store transfers on a clock edge where `st_valid` and `st_ready` are both high. `st_ready` drops only when all slots are full. On the cache side, once `cw_valid` is high with `cw_ready` low, the same entry stays offered until it is accepted. Addresses are word addresses. The line of an address is the address shifted right by `LINE_WORDS_LOG2` bits (default 2).

Top module: `sbuf_top`

## Requirements
- R1: `st_ready` is high exactly when fewer than DEPTH (default 8) entries are held. A store transfers only when `st_valid` and `st_ready` are both high, and a full buffer accepts nothing.
- R2: An entry that entered with `st_owned` low is not offered on the cache port until a fill event and an acknowledgement event for its line have both been applied at clock edges after it entered. The two events may arrive on the same edge or on different edges.
- R3: When `ld_valid` is high and any held entry has an address equal to `ld_addr`, `ld_hit` is high and `ld_data`/`ld_mask` come from the youngest such entry. A store transferring on the same edge becomes visible only after that edge.
- R4: `ld_hit` is low when no held entry matches `ld_addr`, so the load is served by the cache.
- R5: `cw_valid` is high when some entry is eligible. The offered entry is the oldest eligible one. At most one entry leaves per cycle, on a `cw_valid` and `cw_ready` edge.
- R6: With no marked entries held, a complete younger entry is offered even while an older entry still waits on coherence.
- R7: A `fence` pulse marks every entry held before that edge. A store transferring on the same edge is unmarked. `st_ready` is not affected by the pulse.
- R8: While any marked entry is held, only marked entries may be offered on the cache port.
- R9: If `cw_valid` is high and `cw_ready` is low, then on the next cycle `cw_valid` stays high and `cw_addr`, `cw_data` and `cw_mask` are unchanged.
- R10: After reset the buffer is empty: `st_ready` is high, `cw_valid` is low and `ld_hit` is low.
- R11: Coherence events apply only to entries already held. An event for a line with no held entry has no effect on a store that arrives later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Core store request |
| st_ready | output | 1 | Buffer has a free slot |
| st_addr | input | ADDR_W (16) | Store word address |
| st_data | input | DATA_W (32) | Store data |
| st_mask | input | DATA_W/8 (4) | Store byte enables |
| st_owned | input | 1 | The core already holds the line writable; the entry is complete on entry |
| ld_valid | input | 1 | Core load lookup |
| ld_addr | input | ADDR_W | Load word address |
| ld_hit | output | 1 | A held entry matches the load |
| ld_data | output | DATA_W | Forwarded data |
| ld_mask | output | DATA_W/8 | Byte enables of the forwarded entry |
| fence | input | 1 | Write-barrier pulse |
| fill_valid | input | 1 | Line fill has arrived |
| fill_line | input | ADDR_W-LINE_WORDS_LOG2 (14) | Line of the fill event |
| ack_valid | input | 1 | All invalidation acknowledgements are in |
| ack_line | input | ADDR_W-LINE_WORDS_LOG2 | Line of the acknowledgement event |
| cw_valid | output | 1 | Cache write offered |
| cw_ready | input | 1 | Cache accepts the write |
| cw_addr | output | ADDR_W | Cache write word address |
| cw_data | output | DATA_W | Cache write data |
| cw_mask | output | DATA_W/8 | Cache write byte enables |

## Verification
The bench builds a younger owned-line store behind an older pending one and checks that it is offered first when no barrier is held, and held back when a barrier is held. A design that drained in strict arrival order would stall on the first case, and one that ignored the mark would leak a post-barrier store on the second. Forwarding is tested with several stores to one address and with a store transferring on the same edge as the lookup. A wrong priority would return stale data, and a bypass from the input would expose data one cycle early. A fill without an acknowledgement, an event for a line before any store to it, a full buffer, and a stalled cache port with an older entry becoming eligible during the stall are each exercised. A design that mishandled these would drain early, accept a ninth store, or switch the offered payload in the middle of a handshake.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

  // per-entry ordering and coherence state
  typedef struct packed {
    logic mark;   // held when a barrier arrived
    logic fill;   // line data returned
    logic ack;    // invalidation acknowledgements complete
  } sb_flags_t;

endpackage

// File: rtl/sbuf_store.sv
module sbuf_store
  import sbuf_pkg::*;
#(
  parameter int D  = 8,
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int LW = 2,
  localparam int MW = DW / 8,
  localparam int IW = (D > 1) ? $clog2(D) : 1,
  localparam int CW = $clog2(D + 1),
  localparam int LNW = AW - LW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push,
  input  logic [AW-1:0]           push_addr,
  input  logic [DW-1:0]           push_data,
  input  logic [MW-1:0]           push_mask,
  input  logic                    push_owned,
  input  logic                    fence,
  input  logic                    fill_valid,
  input  logic [LNW-1:0]          fill_line,
  input  logic                    ack_valid,
  input  logic [LNW-1:0]          ack_line,
  input  logic                    pop,
  input  logic [IW-1:0]           pop_idx,
  output logic [CW-1:0]           count,
  output logic [D-1:0]            ent_valid,
  output logic [D-1:0][AW-1:0]    ent_addr,
  output logic [D-1:0][DW-1:0]    ent_data,
  output logic [D-1:0][MW-1:0]    ent_mask,
  output sb_flags_t [D-1:0]       ent_flags
);

  logic [CW-1:0]        count_q, n_count;
  logic [D-1:0][AW-1:0] addr_q, n_addr;
  logic [D-1:0][DW-1:0] data_q, n_data;
  logic [D-1:0][MW-1:0] mask_q, n_mask;
  sb_flags_t [D-1:0]    flags_q, m_flags, n_flags;

  // slots 0..count-1 are held, slot 0 oldest
  always_comb begin
    for (int i = 0; i < D; i++) begin
      m_flags[i] = flags_q[i];
      if (i < int'(count_q)) begin
        if (fence) m_flags[i].mark = 1'b1;
        if (fill_valid && addr_q[i][AW-1:LW] == fill_line) m_flags[i].fill = 1'b1;
        if (ack_valid && addr_q[i][AW-1:LW] == ack_line) m_flags[i].ack = 1'b1;
      end
    end

    n_addr  = addr_q;
    n_data  = data_q;
    n_mask  = mask_q;
    n_flags = m_flags;
    if (pop) begin
      for (int i = 0; i < D - 1; i++) begin
        if (i >= int'(pop_idx)) begin
          n_addr[i]  = addr_q[i+1];
          n_data[i]  = data_q[i+1];
          n_mask[i]  = mask_q[i+1];
          n_flags[i] = m_flags[i+1];
        end
      end
    end

    n_count = count_q - CW'(pop);
    if (push) begin
      n_addr[IW'(n_count)]  = push_addr;
      n_data[IW'(n_count)]  = push_data;
      n_mask[IW'(n_count)]  = push_mask;
      n_flags[IW'(n_count)] = '{mark: 1'b0, fill: push_owned, ack: push_owned};
      n_count = n_count + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      mask_q  <= '0;
      flags_q <= '0;
    end else begin
      count_q <= n_count;
      addr_q  <= n_addr;
      data_q  <= n_data;
      mask_q  <= n_mask;
      flags_q <= n_flags;
    end
  end

  always_comb begin
    for (int i = 0; i < D; i++) ent_valid[i] = (i < int'(count_q));
  end

  assign count     = count_q;
  assign ent_addr  = addr_q;
  assign ent_data  = data_q;
  assign ent_mask  = mask_q;
  assign ent_flags = flags_q;

  // R1: the top's ready never lets a push land in a full buffer
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count_q < CW'(D)));

  // R1: the occupancy never exceeds the depth
  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(D));

  // R5: a removal always names a held slot
  assert_pop_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (pop_idx < IW'(count_q) || count_q == CW'(D)));

endmodule

// File: rtl/sbuf_pick.sv
module sbuf_pick
  import sbuf_pkg::*;
#(
  parameter int D = 8,
  localparam int IW = (D > 1) ? $clog2(D) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [D-1:0]      ent_valid,
  input  sb_flags_t [D-1:0] ent_flags,
  input  logic              cw_ready,
  output logic              cw_valid,
  output logic [IW-1:0]     pick_idx
);

  logic [D-1:0]  marked, elig;
  logic          any_mark;
  logic [IW-1:0] oldest;
  logic          lock_q;
  logic [IW-1:0] lock_idx_q;

  always_comb begin
    for (int i = 0; i < D; i++) marked[i] = ent_valid[i] & ent_flags[i].mark;
    any_mark = |marked;
    for (int i = 0; i < D; i++)
      elig[i] = ent_valid[i] & ent_flags[i].fill & ent_flags[i].ack &
                (ent_flags[i].mark | ~any_mark);
    oldest = '0;
    for (int i = D - 1; i >= 0; i--)
      if (elig[i]) oldest = IW'(i);
  end

  // a stalled offer keeps its slot; slots below it never move while stalled
  assign cw_valid = lock_q | (|elig);
  assign pick_idx = lock_q ? lock_idx_q : oldest;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
    end else begin
      lock_q     <= cw_valid & ~cw_ready;
      lock_idx_q <= pick_idx;
    end
  end

  // R2: whatever is offered has finished coherence
  assert_offer_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid |-> (ent_valid[pick_idx] && ent_flags[pick_idx].fill && ent_flags[pick_idx].ack));

  // R8: no unmarked entry leaves while marked ones remain
  assert_barrier_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_valid && any_mark) |-> ent_flags[pick_idx].mark);

endmodule

// File: rtl/sbuf_fwd.sv
module sbuf_fwd #(
  parameter int D  = 8,
  parameter int AW = 16,
  parameter int DW = 32,
  localparam int MW = DW / 8
) (
  input  logic                 ld_valid,
  input  logic [AW-1:0]        ld_addr,
  input  logic [D-1:0]         ent_valid,
  input  logic [D-1:0][AW-1:0] ent_addr,
  input  logic [D-1:0][DW-1:0] ent_data,
  input  logic [D-1:0][MW-1:0] ent_mask,
  output logic                 ld_hit,
  output logic [DW-1:0]        ld_data,
  output logic [MW-1:0]        ld_mask
);

  logic found;

  // higher slots are younger, so the last match wins
  always_comb begin
    found   = 1'b0;
    ld_data = '0;
    ld_mask = '0;
    for (int i = 0; i < D; i++) begin
      if (ent_valid[i] && ent_addr[i] == ld_addr) begin
        found   = 1'b1;
        ld_data = ent_data[i];
        ld_mask = ent_mask[i];
      end
    end
    ld_hit = ld_valid & found;
  end

endmodule

// File: rtl/sbuf_top.sv
module sbuf_top
  import sbuf_pkg::*;
#(
  parameter int DEPTH           = 8,
  parameter int ADDR_W          = 16,
  parameter int DATA_W          = 32,
  parameter int LINE_WORDS_LOG2 = 2,
  localparam int MW  = DATA_W / 8,
  localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int LNW = ADDR_W - LINE_WORDS_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic [MW-1:0]     st_mask,
  input  logic              st_owned,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_hit,
  output logic [DATA_W-1:0] ld_data,
  output logic [MW-1:0]     ld_mask,
  input  logic              fence,
  input  logic              fill_valid,
  input  logic [LNW-1:0]    fill_line,
  input  logic              ack_valid,
  input  logic [LNW-1:0]    ack_line,
  output logic              cw_valid,
  input  logic              cw_ready,
  output logic [ADDR_W-1:0] cw_addr,
  output logic [DATA_W-1:0] cw_data,
  output logic [MW-1:0]     cw_mask
);

  logic [CW-1:0]                count;
  logic [DEPTH-1:0]             ent_valid;
  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
  logic [DEPTH-1:0][DATA_W-1:0] ent_data;
  logic [DEPTH-1:0][MW-1:0]     ent_mask;
  sb_flags_t [DEPTH-1:0]        ent_flags;
  logic [IW-1:0]                pick_idx;
  logic                         push, pop;

  assign st_ready = (count < CW'(DEPTH));
  assign push     = st_valid & st_ready;
  assign pop      = cw_valid & cw_ready;

  sbuf_store #(.D(DEPTH), .AW(ADDR_W), .DW(DATA_W), .LW(LINE_WORDS_LOG2)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_addr(st_addr), .push_data(st_data), .push_mask(st_mask),
    .push_owned(st_owned), .fence(fence),
    .fill_valid(fill_valid), .fill_line(fill_line),
    .ack_valid(ack_valid), .ack_line(ack_line),
    .pop(pop), .pop_idx(pick_idx),
    .count(count), .ent_valid(ent_valid), .ent_addr(ent_addr),
    .ent_data(ent_data), .ent_mask(ent_mask), .ent_flags(ent_flags)
  );

  sbuf_pick #(.D(DEPTH)) u_pick (
    .clk(clk), .rst_n(rst_n),
    .ent_valid(ent_valid), .ent_flags(ent_flags),
    .cw_ready(cw_ready), .cw_valid(cw_valid), .pick_idx(pick_idx)
  );

  sbuf_fwd #(.D(DEPTH), .AW(ADDR_W), .DW(DATA_W)) u_fwd (
    .ld_valid(ld_valid), .ld_addr(ld_addr),
    .ent_valid(ent_valid), .ent_addr(ent_addr), .ent_data(ent_data), .ent_mask(ent_mask),
    .ld_hit(ld_hit), .ld_data(ld_data), .ld_mask(ld_mask)
  );

  assign cw_addr = ent_addr[pick_idx];
  assign cw_data = ent_data[pick_idx];
  assign cw_mask = ent_mask[pick_idx];

  // R9: a stalled cache write keeps its payload
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_valid && !cw_ready) |=> (cw_valid && $stable(cw_addr) && $stable(cw_data) && $stable(cw_mask)));

endmodule

// File: tb/tb_sbuf_top.sv
`timescale 1ns/1ps
module tb_sbuf_top;
  localparam int D = 8, AW = 16, DW = 32, MW = 4, LW = 2, LNW = AW - LW;

  logic clk = 1'b0, rst_n;
  logic st_valid, st_ready, st_owned, ld_valid, ld_hit, fence;
  logic fill_valid, ack_valid, cw_valid, cw_ready;
  logic [AW-1:0] st_addr, ld_addr, cw_addr;
  logic [DW-1:0] st_data, ld_data, cw_data;
  logic [MW-1:0] st_mask, ld_mask, cw_mask;
  logic [LNW-1:0] fill_line, ack_line;

  sbuf_top #(.DEPTH(D), .ADDR_W(AW), .DATA_W(DW), .LINE_WORDS_LOG2(LW)) dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_mask(st_mask), .st_owned(st_owned),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data),
    .ld_mask(ld_mask), .fence(fence), .fill_valid(fill_valid), .fill_line(fill_line),
    .ack_valid(ack_valid), .ack_line(ack_line), .cw_valid(cw_valid), .cw_ready(cw_ready),
    .cw_addr(cw_addr), .cw_data(cw_data), .cw_mask(cw_mask));

  always #4 clk = ~clk;

  typedef struct {
    logic [AW-1:0] a; logic [DW-1:0] d; logic [MW-1:0] m;
    bit mk; bit f; bit k;
  } ent_t;
  ent_t q[$];
  bit   ml;
  int   mli;
  int   nchk = 0, nfail = 0;
  bit   done = 1'b0;

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic int model_pick();
    bit anym = 1'b0;
    if (ml) return mli;
    foreach (q[i]) if (q[i].mk) anym = 1'b1;
    foreach (q[i]) if (q[i].f && q[i].k && (q[i].mk || !anym)) return i;
    return -1;
  endfunction

  function automatic int model_fwd(logic [AW-1:0] a);
    int r = -1;
    foreach (q[i]) if (q[i].a == a) r = i;
    return r;
  endfunction

  // compare against the model, then advance the model across one edge
  task automatic tick();
    int p, h;
    bit rdy;
    #1;
    rdy = (q.size() < D);
    p = model_pick();
    chk("R1 st_ready", st_ready, rdy);
    chk("R5 cw_valid", cw_valid, p >= 0);
    if (p >= 0) begin
      chk("R5 cw_addr", cw_addr, q[p].a);
      chk("R5 cw_data", cw_data, q[p].d);
      chk("R5 cw_mask", cw_mask, q[p].m);
    end
    if (ld_valid) begin
      h = model_fwd(ld_addr);
      chk("R3/R4 ld_hit", ld_hit, h >= 0);
      if (h >= 0) begin
        chk("R3 ld_data", ld_data, q[h].d);
        chk("R3 ld_mask", ld_mask, q[h].m);
      end
    end
    foreach (q[i]) begin
      if (fence) q[i].mk = 1'b1;
      if (fill_valid && q[i].a[AW-1:LW] == fill_line) q[i].f = 1'b1;
      if (ack_valid && q[i].a[AW-1:LW] == ack_line) q[i].k = 1'b1;
    end
    ml  = (p >= 0) && !cw_ready;
    mli = p;
    if (p >= 0 && cw_ready) q.delete(p);
    if (st_valid && rdy) q.push_back('{st_addr, st_data, st_mask, 1'b0, st_owned, st_owned});
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    st_valid = 0; st_addr = '0; st_data = '0; st_mask = '0; st_owned = 0;
    ld_valid = 0; ld_addr = '0; fence = 0;
    fill_valid = 0; fill_line = '0; ack_valid = 0; ack_line = '0; cw_ready = 0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    q.delete();
    ml = 0; mli = 0;
    #1;
    chk("R10 st_ready after reset", st_ready, 1);
    chk("R10 cw_valid after reset", cw_valid, 0);
  endtask

  task automatic store(logic [AW-1:0] a, logic [DW-1:0] d, bit own);
    st_valid = 1; st_addr = a; st_data = d; st_mask = 4'hF; st_owned = own;
  endtask

  initial begin
    int dummy;
    dummy = $urandom(32'h1F2E);
    do_reset();
    ld_valid = 1; ld_addr = 16'h0010;
    #1 chk("R10 ld_hit after reset", ld_hit, 0);
    ld_valid = 0;

    // younger owned store overtakes an older pending one; stalled port holds
    store(16'h0010, 32'hAAAA_0001, 0); tick();
    store(16'h0021, 32'hBBBB_0002, 1); tick();
    st_valid = 0;
    #1 chk("R6 younger owned store offered", cw_addr, 16'h0021);
    chk("R6 offer valid", cw_valid, 1);
    tick();
    #1 chk("R9 payload held while stalled", cw_addr, 16'h0021);
    ld_valid = 1; ld_addr = 16'h0010;
    #1 chk("R3 forward single match", ld_data, 32'hAAAA_0001);
    store(16'h0010, 32'hCCCC_0003, 0);
    #1 chk("R3 same-edge store not visible yet", ld_data, 32'hAAAA_0001);
    tick();
    st_valid = 0;
    #1 chk("R3 youngest match wins", ld_data, 32'hCCCC_0003);
    ld_addr = 16'h0030;
    #1 chk("R4 miss goes to cache", ld_hit, 0);
    ld_valid = 0;
    tick();

    // barrier keeps a younger owned store behind a marked pending one
    do_reset();
    cw_ready = 1;
    store(16'h0040, 32'h1111_0040, 0); tick();
    fence = 1; store(16'h0051, 32'h2222_0051, 1);
    #1 chk("R7 st_ready unaffected by fence", st_ready, 1);
    tick();
    fence = 0; st_valid = 0;
    #1 chk("R8 unmarked held back", cw_valid, 0);
    fill_valid = 1; fill_line = 14'h10; tick();
    fill_valid = 0;
    #1 chk("R2 fill alone not enough", cw_valid, 0);
    ack_valid = 1; ack_line = 14'h10; tick();
    ack_valid = 0;
    #1 chk("R7 marked entry drains first", cw_addr, 16'h0040);
    tick();
    #1 chk("R8 unmarked follows", cw_addr, 16'h0051);
    tick();

    // full buffer
    do_reset();
    for (int i = 0; i < D; i++) begin store(16'(16'h0100 + i * 8), 32'(i), 0); tick(); end
    #1 chk("R1 full buffer not ready", st_ready, 0);
    store(16'h0200, 32'hDEAD, 1); tick();
    st_valid = 0; tick();

    // event before any store to that line
    do_reset();
    cw_ready = 1;
    fill_valid = 1; fill_line = 14'h3; ack_valid = 1; ack_line = 14'h3; tick();
    fill_valid = 0; ack_valid = 0;
    store(16'h000C, 32'h5555_000C, 0); tick();
    st_valid = 0;
    #1 chk("R11 earlier event ignored", cw_valid, 0);
    tick();

    // constrained random
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      st_valid   = ($urandom % 2) == 0;
      st_addr    = 16'($urandom % 16);
      st_data    = $urandom;
      st_mask    = 4'($urandom % 16);
      st_owned   = ($urandom % 10) < 3;
      ld_valid   = ($urandom % 2) == 0;
      ld_addr    = 16'($urandom % 16);
      fence      = ($urandom % 20) == 0;
      fill_valid = ($urandom % 5) == 0;
      fill_line  = 14'($urandom % 4);
      ack_valid  = ($urandom % 5) == 0;
      ack_line   = 14'($urandom % 4);
      cw_ready   = ($urandom % 10) < 6;
      tick();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

endmodule